// File: doc/BRIEF.md
# Parallel I/O Port with Edge Capture

A parallel I/O peripheral with up to 32 pins, sitting on a simple word-addressed register bus. Each pin has an output value, a direction bit, an interrupt-enable bit and a sticky edge-capture bit. Pin inputs pass through a two-flop synchronizer. The port drives output values and output enables for pins configured as outputs. It records input transitions of a trigger kind that is fixed by a build parameter. It raises one interrupt line from the enabled pending sources.

The trigger kind is one of rising, falling, both edges or level-high. In the three edge kinds, captured edges stay set until software writes a one to them. In level-high mode the interrupt follows the enabled synchronized pin levels directly, and the capture word reads as zero. Software uses whole-word read-modify-write, so every register reads back its full current value.

Word map, using byte offsets: 0x0 pin data / output value, 0x4 direction, 0x8 interrupt enable, 0xC edge capture.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset the direction, output value, interrupt enable and capture words are zero, all pins are inputs (pin_oe_o = 0) and irq_o is low.
- R2: A write to offset 0x4, 0x8 or 0x0 stores wdata_i[N_PINS-1:0]. A later read of 0x4 or 0x8 returns the stored value zero-extended, with bits at N_PINS and above reading 0.
- R3: Read data appears on rdata_o on the clock edge that accepts the read. A read of any offset other than 0x0, 0x4, 0x8 or 0xC (including unaligned offsets) returns 0.
- R4: pin_oe_o equals the direction word (1 = output). pin_o equals the output-value word on output pins and is 0 on input pins.
- R5: A read of offset 0x0 returns the synchronized level of pin_i, one bit per pin.
- R6: In rising mode, a 0-to-1 transition on a pin sets its capture bit (offset 0xC), and a 1-to-0 transition sets nothing.
- R7: In falling mode only 1-to-0 transitions set capture bits. In both-edges mode transitions of either direction set them.
- R8: Capture bits are sticky. Writing 1 to a capture bit at 0xC clears it, and writing 0 leaves it unchanged.
- R9: In edge modes irq_o is high exactly when (capture AND enable) is nonzero. An enable bit of 0 blocks that pin, and the capture bit stays readable.
- R10: In level-high mode irq_o is high exactly when (synchronized pins AND enable) is nonzero, and the capture word reads 0.
- R11: When a new edge and a write-one-to-clear hit the same capture bit in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the accessed word |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, registered |
| pin_i | input | N_PINS | Pin input levels (asynchronous) |
| pin_o | output | N_PINS | Pin output values |
| pin_oe_o | output | N_PINS | Pin output enables |
| irq_o | output | 1 | Interrupt request |

## Verification
The hazard case is a clearing write to the capture word that lands on the same clock edge as a fresh edge on the same pin. The bench makes a pin pending and then lowers it. It then raises the pin again and times the write-one-to-clear so that the write is accepted on the exact edge where the synchronized transition is captured. The design is judged correct if the bit reads back as set afterwards. A second clear with no edge present must then remove the bit, which shows that the clear path itself works.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    TRIG_RISE  = 2'd0,
    TRIG_FALL  = 2'd1,
    TRIG_BOTH  = 2'd2,
    TRIG_LEVEL = 2'd3
  } trig_e;

  // word index = byte offset [3:2]
  localparam logic [1:0] WIDX_DATA = 2'd0;
  localparam logic [1:0] WIDX_DIR  = 2'd1;
  localparam logic [1:0] WIDX_IEN  = 2'd2;
  localparam logic [1:0] WIDX_CAP  = 2'd3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_cap.sv
module gpio_edge_cap
  import gpio_pkg::*;
#(
  parameter int    N_PINS  = 32,
  parameter trig_e TRIGGER = TRIG_RISE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] lvl_i,
  input  logic [N_PINS-1:0] clr_i,
  output logic [N_PINS-1:0] cap_o
);
  if (TRIGGER == TRIG_LEVEL) begin : g_level
    assign cap_o = '0;
  end else begin : g_edge
    logic [N_PINS-1:0] prev_q;
    logic [N_PINS-1:0] cap_q;
    logic [N_PINS-1:0] hit;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= '0;
      else         prev_q <= lvl_i;
    end

    if (TRIGGER == TRIG_RISE) begin : g_rise
      assign hit = lvl_i & ~prev_q;
    end else if (TRIGGER == TRIG_FALL) begin : g_fall
      assign hit = ~lvl_i & prev_q;
    end else begin : g_both
      assign hit = lvl_i ^ prev_q;
    end

    // new edge overrides a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cap_q <= '0;
      else         cap_q <= (cap_q & ~clr_i) | hit;
    end

    assign cap_o = cap_q;

    AST_CAP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((cap_q & $past(cap_q & ~clr_i)) == $past(cap_q & ~clr_i))); // R8

    AST_EDGE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(clr_i & hit)) |=> ((cap_q & $past(clr_i & hit)) == $past(clr_i & hit))); // R11
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int N_PINS = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_PINS-1:0] lvl_i,
  input  logic [N_PINS-1:0] cap_i,
  output logic [N_PINS-1:0] dir_o,
  output logic [N_PINS-1:0] out_o,
  output logic [N_PINS-1:0] ien_o,
  output logic [N_PINS-1:0] clr_o
);
  logic              addr_ok;
  logic [1:0]        widx;
  logic              wr, rd;
  logic [N_PINS-1:0] wbits;
  logic [N_PINS-1:0] dir_q, out_q, ien_q;
  logic [N_PINS-1:0] rsel;
  logic [DATA_W-1:0] rdata_q;

  assign widx    = addr_i[3:2];
  assign addr_ok = (addr_i[1:0] == 2'b00) && ((addr_i >> 4) == '0);
  assign wr      = req_i && we_i && addr_ok;
  assign rd      = req_i && !we_i;
  assign wbits   = wdata_i[N_PINS-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      out_q <= '0;
      ien_q <= '0;
    end else if (wr) begin
      case (widx)
        WIDX_DATA: out_q <= wbits;
        WIDX_DIR:  dir_q <= wbits;
        WIDX_IEN:  ien_q <= wbits;
        default:   ;
      endcase
    end
  end

  assign clr_o = (wr && widx == WIDX_CAP) ? wbits : '0;

  always_comb begin
    case (widx)
      WIDX_DATA: rsel = lvl_i;
      WIDX_DIR:  rsel = dir_q;
      WIDX_IEN:  rsel = ien_q;
      default:   rsel = cap_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= addr_ok ? DATA_W'(rsel) : '0;
  end

  assign rdata_o = rdata_q;
  assign dir_o   = dir_q;
  assign out_o   = out_q;
  assign ien_o   = ien_q;

  AST_UNDEF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !addr_ok) |=> (rdata_o == '0)); // R3

  AST_IEN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && addr_i == ADDR_W'(8)) |=> $stable(ien_q)); // R2
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_pkg::*;
#(
  parameter int    N_PINS  = 32,
  parameter int    DATA_W  = 32,
  parameter int    ADDR_W  = 4,
  parameter int    SYNC_N  = 2,
  parameter trig_e TRIGGER = TRIG_RISE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] pin_o,
  output logic [N_PINS-1:0] pin_oe_o,
  output logic              irq_o
);
  logic [N_PINS-1:0] lvl, cap, clr, dir, outv, ien;

  gpio_sync #(.WIDTH(N_PINS), .STAGES(SYNC_N)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(lvl)
  );

  gpio_edge_cap #(.N_PINS(N_PINS), .TRIGGER(TRIGGER)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl), .clr_i(clr), .cap_o(cap)
  );

  gpio_regs #(.N_PINS(N_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .lvl_i(lvl), .cap_i(cap), .dir_o(dir), .out_o(outv), .ien_o(ien),
    .clr_o(clr)
  );

  assign pin_oe_o = dir;
  assign pin_o    = outv & dir;

  if (TRIGGER == TRIG_LEVEL) begin : g_irq_lvl
    assign irq_o = |(lvl & ien);
  end else begin : g_irq_edge
    assign irq_o = |(cap & ien);
  end

  AST_OUT_ON_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_o & ~pin_oe_o) == '0)); // R4

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien == '0) |-> !irq_o); // R9
endmodule

// File: tb/gpio_edge_port_bench.sv
`timescale 1ns/1ps
module gpio_edge_port_bench;
  import gpio_pkg::*;

  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [3:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [NP-1:0] ext = '0;
  logic [31:0]   rd_r, rd_f, rd_b, rd_l;
  logic [NP-1:0] po_r, po_f, po_b, po_l, oe_r, oe_f, oe_b, oe_l;
  logic          irq_r, irq_f, irq_b, irq_l;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_edge_port #(.N_PINS(NP), .TRIGGER(TRIG_RISE)) u_gpio_edge_port (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rd_r), .pin_i(ext), .pin_o(po_r),
    .pin_oe_o(oe_r), .irq_o(irq_r));
  gpio_edge_port #(.N_PINS(NP), .TRIGGER(TRIG_FALL)) u_gpio_edge_port_fall (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rd_f), .pin_i(ext), .pin_o(po_f),
    .pin_oe_o(oe_f), .irq_o(irq_f));
  gpio_edge_port #(.N_PINS(NP), .TRIGGER(TRIG_BOTH)) u_gpio_edge_port_both (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rd_b), .pin_i(ext), .pin_o(po_b),
    .pin_oe_o(oe_b), .irq_o(irq_b));
  gpio_edge_port #(.N_PINS(NP), .TRIGGER(TRIG_LEVEL)) u_gpio_edge_port_lvl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rd_l), .pin_i(ext), .pin_o(po_l),
    .pin_oe_o(oe_l), .irq_o(irq_l));

  typedef struct packed {
    logic        wr;
    logic [3:0]  a;
    logic [31:0] d;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'h4, 32'hFFFF_FFFF},
    '{1'b0, 4'h4, 32'h0000_00FF},
    '{1'b1, 4'h8, 32'hFFFF_00A5},
    '{1'b0, 4'h8, 32'h0000_00A5},
    '{1'b1, 4'h0, 32'h1234_5678},
    '{1'b0, 4'h0, 32'h0000_0000},
    '{1'b0, 4'h2, 32'h0000_0000},
    '{1'b0, 4'h5, 32'h0000_0000},
    '{1'b1, 4'h4, 32'h0000_000F},
    '{1'b0, 4'h4, 32'h0000_000F}
  };

  task automatic check(input string req_s, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req_s, act, exp);
    end
  endtask

  // called at a negedge, returns at a negedge
  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a);
    req = 1'b1; we = 1'b0; addr = a;
    @(posedge clk); @(negedge clk);
    req = 1'b0;
  endtask

  task automatic set_pins(input logic [NP-1:0] v);
    ext = v;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 oe", 32'(oe_r), 32'h0);
    check("R1 irq", 32'(irq_r), 32'h0);
    bus_rd(4'h0); check("R1 data", rd_r, 32'h0);
    bus_rd(4'h4); check("R1 dir", rd_r, 32'h0);
    bus_rd(4'h8); check("R1 ien", rd_r, 32'h0);
    bus_rd(4'hC); check("R1 cap", rd_r, 32'h0);

    // R2 R3 table walk
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) bus_wr(VECS[i].a, VECS[i].d);
      else begin
        bus_rd(VECS[i].a);
        check((VECS[i].a[1:0] != 2'b00) ? "R3 table" : "R2 table", rd_r, VECS[i].d);
      end
    end

    // R4 drive: dir=0x0F, out=0x78
    check("R4 oe", 32'(oe_r), 32'h0F);
    check("R4 pin_o", 32'(po_r), 32'h08);

    // R5 R6 R7 rising set
    set_pins(8'h5A);
    bus_rd(4'h0); check("R5 data", rd_r, 32'h5A);
    bus_rd(4'hC); check("R6 rise cap", rd_r, 32'h5A);
    check("R7 fall cap none", rd_f, 32'h00);
    check("R7 both cap rise", rd_b, 32'h5A);
    bus_wr(4'hC, 32'hFF);
    set_pins(8'h00);
    bus_rd(4'hC); check("R6 rise ignores fall", rd_r, 32'h00);
    check("R7 fall cap", rd_f, 32'h5A);
    check("R7 both cap", rd_b, 32'h5A);
    bus_wr(4'hC, 32'hFF);

    // R8 R9 sticky, clear, irq (ien = 0xA5)
    set_pins(8'h01);
    check("R9 irq on", 32'(irq_r), 32'h1);
    set_pins(8'h00);
    bus_rd(4'hC); check("R8 sticky", rd_r, 32'h01);
    bus_wr(4'hC, 32'h00);
    bus_rd(4'hC); check("R8 write0 keeps", rd_r, 32'h01);
    bus_wr(4'hC, 32'h01);
    bus_rd(4'hC); check("R8 w1c", rd_r, 32'h00);
    check("R9 irq off", 32'(irq_r), 32'h0);

    set_pins(8'h02);
    check("R9 masked irq", 32'(irq_r), 32'h0);
    bus_rd(4'hC); check("R9 masked cap", rd_r, 32'h02);
    bus_wr(4'h8, 32'hFF);
    check("R9 unmask irq", 32'(irq_r), 32'h1);
    bus_wr(4'hC, 32'hFF);
    set_pins(8'h00);
    bus_wr(4'hC, 32'hFF);

    // R10 level mode, ien = 0x0F
    bus_wr(4'h8, 32'h0F);
    set_pins(8'h30);
    check("R10 lvl masked", 32'(irq_l), 32'h0);
    set_pins(8'h34);
    check("R10 lvl on", 32'(irq_l), 32'h1);
    bus_rd(4'hC); check("R10 lvl cap", rd_l, 32'h0);
    set_pins(8'h00);
    check("R10 lvl off", 32'(irq_l), 32'h0);
    bus_wr(4'hC, 32'hFF);

    // R11 edge vs clear collision
    set_pins(8'h01);
    set_pins(8'h00);
    ext = 8'h01;
    @(posedge clk); @(posedge clk); @(negedge clk);
    bus_wr(4'hC, 32'h01);
    bus_rd(4'hC); check("R11 edge wins", rd_r, 32'h01);
    bus_wr(4'hC, 32'h01);
    bus_rd(4'hC); check("R11 clear after", rd_r, 32'h00);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule